// File: doc/BRIEF.md
# Slice-and-Protect Transmit Encoder

This block sits between a buffer FIFO of wide parallel words and the parallel input of a serializer. It accepts one 40-bit word at a time over a valid/ready handshake. It cuts each word into four 10-bit slices and sends them out one per clock, starting with the most significant slice. A tag bit is added to each slice to mark the start of a channel packet. The resulting 11-bit message is turned into a 16-bit codeword that can correct any single bit error and detect any double bit error.

The upstream side raises `in_first` with a word when that word opens a new packet. Only the first slice of that word carries a set tag. Every other slice goes out with a clear tag. The handshake only opens while the last slice of the current word is in progress, or when nothing is in progress. Because of this, a steady stream of words leaves as a gap-free stream of codewords, four per word.

Top module: `slice_hamming_tx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1. Reset drops any word that is in progress, and no codeword from it appears afterwards.
- R2: An accepted word produces exactly four codewords on consecutive cycles. Their slices are, in order, word bits 39:30, 29:20, 19:10 and 9:0.
- R3: The tag bit (codeword bit 15) is 1 only in the first codeword of a word that was accepted with `in_first` high. It is 0 in all other codewords, so two consecutive valid codewords never both carry a set tag.
- R4: Codeword layout. Bit 0 is even parity over bits 15:1. Bits 1, 2, 4 and 8 are check bits. The check bit at bit 2^k makes the XOR of all bits 15:1 whose index has bit k set equal to 0. The message fills the remaining positions in ascending order: slice bits 0..9 go to positions 3,5,6,7,9,10,11,12,13,14, and the tag goes to position 15. The XOR of the indices of all set bits among 15:1 is therefore 0, and the whole word has even parity.
- R5: Inverting any single bit of a valid codeword gives a word whose syndrome (the XOR of set-bit indices) and overall parity locate that bit. Inverting the located bit restores the original codeword.
- R6: Inverting any two distinct bits of a valid codeword gives even overall parity and a nonzero syndrome, so the error is detected as a double error.
- R7: `in_ready` is 1 when no word is in progress, or while the fourth slice of the current word is being encoded. It is 0 while the first three slices are being encoded.
- R8: When a new word is offered on the cycle `in_ready` is high during a fourth slice, its first codeword follows the previous word's last codeword with no idle cycle.
- R9: The first codeword of a word is valid on the second rising edge after the edge that accepted the word. The following slices come on the next three edges.
- R10: `in_valid`, `in_data` and `in_first` have no effect while `in_ready` is 0. The codewords that follow are those of the accepted word only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block takes the offered word on this edge |
| in_data | input | 40 | Word to be sliced |
| in_first | input | 1 | Offered word starts a new channel packet |
| out_valid | output | 1 | `out_code` holds a codeword this cycle |
| out_code | output | 16 | Protected codeword for the serializer |

## Verification
A word handed over at a rising edge appears as its first codeword after the second edge that follows, and its other three slices follow on the next three edges. The bench logs every accepted word together with the cycle each of its four codewords is due. Each codeword is decoded at the falling edge of exactly that cycle and compared by syndrome, by message and by arrival cycle. `in_ready` is predicted one cycle at a time from a count of the slices left in the current word, and is compared at every falling edge. The bench offers words only at falling edges, after reading `in_ready`, so each acceptance happens at a known edge.

// File: rtl/slicer_pkg.sv
package slicer_pkg;

    parameter int SLICE_W        = 10;
    parameter int NUM_SLICES_DEF = 4;
    parameter int MSG_W          = SLICE_W + 1;

    function automatic int ham_checks(int m);
        int r;
        r = 0;
        while ((1 << r) < m + r + 1) r++;
        return r;
    endfunction

    parameter int CHK_W   = ham_checks(MSG_W);
    parameter int CODE_W  = MSG_W + CHK_W + 1;
    parameter int TAG_POS = CODE_W - 1;

    typedef logic [SLICE_W-1:0] slice_t;
    typedef logic [CODE_W-1:0]  code_t;

    typedef struct packed {
        logic   tag;
        slice_t data;
    } msg_t;

    function automatic bit is_pow2(int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic code_t place_msg(msg_t m);
        code_t c;
        logic [MSG_W-1:0] flat;
        int j;
        c = '0;
        flat = m;
        j = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_pow2(p)) begin
                c[p] = flat[j];
                j++;
            end
        end
        return c;
    endfunction

    function automatic code_t cover_mask(int k);
        code_t msk;
        msk = '0;
        for (int p = 1; p < CODE_W; p++) begin
            if (((p >> k) & 1) == 1 && p != (1 << k)) msk[p] = 1'b1;
        end
        return msk;
    endfunction

endpackage

// File: rtl/slice_sequencer.sv
module slice_sequencer
    import slicer_pkg::*;
#(
    parameter int NUM_SLICES = NUM_SLICES_DEF,
    localparam int WORD_W = NUM_SLICES * SLICE_W,
    localparam int IDX_W  = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_first,
    output logic              in_ready,
    output logic              msg_valid,
    output msg_t              msg
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLICES - 1);

    logic [NUM_SLICES-1:0][SLICE_W-1:0] word_q;
    logic                               first_q;
    logic [IDX_W-1:0]                   idx_q;
    logic                               busy_q;
    logic                               last;
    logic                               take;
    logic [IDX_W-1:0]                   pick;

    assign last     = (idx_q == LAST_IDX);
    assign in_ready = !busy_q || last;
    assign take     = in_valid && in_ready;
    assign pick     = LAST_IDX - idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            first_q <= 1'b0;
            word_q  <= '0;
        end else if (take) begin
            busy_q  <= 1'b1;
            idx_q   <= '0;
            first_q <= in_first;
            word_q  <= in_data;
        end else if (busy_q) begin
            if (last) begin
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        msg_valid = busy_q;
        msg.data  = word_q[pick];
        msg.tag   = first_q && (idx_q == '0);
    end

endmodule

// File: rtl/secded_encoder.sv
module secded_encoder
    import slicer_pkg::*;
(
    input  msg_t  msg,
    output code_t code
);

    code_t              spread;
    code_t              body;
    logic [CHK_W-1:0]   chk;

    assign spread = place_msg(msg);

    genvar k;
    generate
        for (k = 0; k < CHK_W; k++) begin : g_chk
            localparam code_t MASK = cover_mask(k);
            assign chk[k] = ^(spread & MASK);
        end
    endgenerate

    always_comb begin
        body = spread;
        for (int b = 0; b < CHK_W; b++) begin
            body[1 << b] = chk[b];
        end
    end

    assign code = body | {{(CODE_W-1){1'b0}}, ^body[CODE_W-1:1]};

endmodule

// File: rtl/code_register.sv
module code_register
    import slicer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  d_valid,
    input  code_t d_code,
    output logic  q_valid,
    output code_t q_code
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_code  <= '0;
        end else begin
            q_valid <= d_valid;
            if (d_valid) q_code <= d_code;
        end
    end

endmodule

// File: rtl/slice_hamming_tx.sv
module slice_hamming_tx
    import slicer_pkg::*;
#(
    parameter int NUM_SLICES = NUM_SLICES_DEF,
    localparam int WORD_W = NUM_SLICES * SLICE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_first,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code
);

    msg_t  cur_msg;
    logic  cur_valid;
    code_t cur_code;

    slice_sequencer #(.NUM_SLICES(NUM_SLICES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_first  (in_first),
        .in_ready  (in_ready),
        .msg_valid (cur_valid),
        .msg       (cur_msg)
    );

    secded_encoder u_enc (
        .msg  (cur_msg),
        .code (cur_code)
    );

    code_register u_oreg (
        .clk     (clk),
        .rst     (rst),
        .d_valid (cur_valid),
        .d_code  (cur_code),
        .q_valid (out_valid),
        .q_code  (out_code)
    );

endmodule

// File: rtl/slice_hamming_tx_checker.sv
module slice_hamming_tx_checker
    import slicer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [CODE_W-1:0] out_code
);

    function automatic int syndrome_of(logic [CODE_W-1:0] c);
        int s;
        s = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (c[p]) s = s ^ p;
        end
        return s;
    endfunction

    assert_even_parity_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (^out_code) == 1'b0);

    assert_zero_syndrome_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> syndrome_of(out_code) == 0);

    assert_first_code_latency_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> ##2 out_valid);

    assert_stall_means_stream_R7: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> out_valid);

    assert_tag_not_repeated_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_code[TAG_POS]) |=> !(out_valid && out_code[TAG_POS]));

endmodule

bind slice_hamming_tx slice_hamming_tx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_code  (out_code)
);

// File: tb/tb_slice_hamming_tx.sv
module tb_slice_hamming_tx;

    localparam int NS       = 4;
    localparam int SW       = 10;
    localparam int WW       = NS * SW;
    localparam int N_SWEEP  = 1024;
    localparam int N_GAPPY  = 256;
    localparam int TOTAL    = N_SWEEP + N_GAPPY;
    localparam int LIMIT    = 20000;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_ready;
    logic [WW-1:0] in_data;
    logic          in_first;
    logic          out_valid;
    logic [15:0]   out_code;

    always #5 clk = ~clk;

    slice_hamming_tx dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_first  (in_first),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [10:0] expq [0:255];
    int          dueq [0:255];
    int qh = 0;
    int qt = 0;
    int cyc = 0;
    int rem = 0;
    int wi = 0;
    int n_flip = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    function automatic int syn(logic [15:0] c);
        int s;
        s = 0;
        for (int p = 1; p < 16; p++) if (c[p]) s = s ^ p;
        return s;
    endfunction

    function automatic logic [10:0] extract(logic [15:0] c);
        logic [10:0] m;
        int j;
        j = 0;
        m = '0;
        for (int p = 1; p < 16; p++) begin
            if ((p & (p - 1)) != 0) begin
                m[j] = c[p];
                j++;
            end
        end
        return m;
    endfunction

    function automatic logic [15:0] repair(logic [15:0] c);
        logic [15:0] r;
        r = c;
        if (^c) r[syn(c)] = ~r[syn(c)];
        return r;
    endfunction

    function automatic logic [WW-1:0] make_word(int i);
        logic [WW-1:0] w;
        for (int k = 0; k < NS; k++) begin
            int v;
            if (i < N_SWEEP) v = (i + k * 257) % 1024;
            else v = (i * 613 + k * 131 + 77) % 1024;
            w[(NS-1-k)*SW +: SW] = v[SW-1:0];
        end
        return w;
    endfunction

    task automatic sample_outputs();
        if (out_valid) begin
            if (qh == qt) begin
                check(1'b0, "R2", "codeword with nothing pending", int'(out_code), 0);
            end else begin
                check(syn(out_code) == 0, "R4", "syndrome", syn(out_code), 0);
                check((^out_code) == 1'b0, "R4", "overall parity", int'(^out_code), 0);
                check(extract(out_code) == expq[qh], "R2/R3", "slice and tag",
                      int'(extract(out_code)), int'(expq[qh]));
                check(dueq[qh] == cyc, "R9/R8", "arrival cycle", cyc, dueq[qh]);
                if (n_flip < 64) begin
                    n_flip++;
                    for (int b = 0; b < 16; b++) begin
                        logic [15:0] one, two;
                        one = out_code ^ (16'd1 << b);
                        check(repair(one) == out_code, "R5", "single flip repair",
                              int'(repair(one)), int'(out_code));
                        two = one ^ (16'd1 << ((b + 1) % 16));
                        check((^two) == 1'b0 && syn(two) != 0, "R6", "double flip detect",
                              syn(two), 1);
                    end
                end
                qh = (qh + 1) % 256;
            end
        end else if (qh != qt && dueq[qh] <= cyc) begin
            check(1'b0, "R8", "missing codeword", 0, int'(expq[qh]));
            qh = (qh + 1) % 256;
        end
    endtask

    task automatic drive_inputs();
        bit want;
        want = (wi < N_SWEEP) || (wi < TOTAL && (cyc % 7) < 4);
        if (in_ready && want) begin
            logic [WW-1:0] w;
            bit f;
            w = make_word(wi);
            f = (wi % 3 == 0);
            in_valid = 1'b1;
            in_data  = w;
            in_first = f;
            for (int k = 0; k < NS; k++) begin
                expq[qt] = {f && (k == 0), w[(NS-1-k)*SW +: SW]};
                dueq[qt] = cyc + 2 + k;
                qt = (qt + 1) % 256;
            end
            wi++;
            rem = NS;
        end else begin
            // R10: offers made while in_ready is low must be dropped
            in_valid = !in_ready;
            in_data  = ~make_word(wi + 5);
            in_first = 1'b1;
            if (rem > 0) rem--;
        end
    endtask

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = '0;
        in_first = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

        while ((wi < TOTAL || qh != qt) && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            sample_outputs();
            check(in_ready == (rem <= 1), "R7", "in_ready", int'(in_ready), int'(rem <= 1));
            drive_inputs();
        end
        if (cyc >= LIMIT) check(1'b0, "R2", "watchdog expired", cyc, LIMIT);

        // R1: reset in the middle of a word drops it
        in_valid = 1'b0;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = make_word(3);
        in_first = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0, "R1", "out_valid after mid-word reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready after mid-word reset", int'(in_ready), 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1", "dropped word stays silent", int'(out_valid), 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule